// File: doc/BRIEF.md
# Serial-Loaded Digital Potentiometer Controller

This block is the digital control core of a 128-position resistor-divider potentiometer with a 7-bit wiper code. A host loads a new code over a three-wire serial link: a serial clock, an active-low select and a data line. While select is low, each serial clock rising edge moves one data bit into a 7-bit shift register, most significant bit first. When select rises, the shift register is copied into the wiper latch. The code D sets the divider ratio D/128. Code 127 is full scale, 64 is the centre, 1 is one step above the bottom and 0 is zero scale.

The oldest bit in the shift register goes out on a serial output. That output is modelled as an open-drain pull-down enable, so several controllers can be chained into one long shift register. An asynchronous active-low reset centres the wiper and clears the shift register. An active-low shutdown opens the top-terminal switch, ties the wiper to the bottom terminal and releases the serial output. The stored codes are kept through shutdown.

All serial and control inputs are sampled by a free-running core clock. A select edge and a serial clock edge that fall in the same sampled cycle are ordered so that the commit takes the contents from before that clock.

Top module: `dpot_ctrl`

## Requirements
- R1: While select is low, each serial clock rising edge shifts the data bit into bit 0 of the shift register, and the other bits move up by one place.
- R2: The pull-down enable `sdo_pull_low` is 1 exactly when shutdown is inactive and bit 6 of the shift register is 0. The resolved line therefore shows the bit entered seven clocks earlier, and two chained controllers take a 14-bit frame whose first 7 bits end up in the second controller.
- R3: When a frame has more than seven clocks, only the last seven bits stay in the shift register. A frame with fewer than seven clocks shifts the old contents up by that many places.
- R4: A rising edge on select copies the shift register into `wiper_code`.
- R5: While select is high, serial clock and data activity changes neither the wiper latch nor the shift register.
- R6: While `rs_n` is low, `wiper_code` is 0x40 and the shift register is all zeros, whatever select and the serial clock do. The all-zero contents make the resolved output read 0.
- R7: When `rs_n` is released while select is high, `wiper_code` stays at 0x40.
- R8: While `shdn_n` is low, `a_switch_on` is 0, `wb_short` is 1 and `sdo_pull_low` is 0.
- R9: Shutdown keeps the contents of the wiper latch and the shift register. When `shdn_n` returns high, the previous code and output level are restored.
- R10: A select rising edge sampled in the same core cycle as a serial clock rising edge commits the contents from before that clock edge, and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rs_n | input | 1 | Asynchronous active-low reset to the centre code |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| cs_n | input | 1 | Active-low frame select; its rising edge commits |
| sdi | input | 1 | Serial data in, MSB first |
| shdn_n | input | 1 | Active-low shutdown |
| wiper_code | output | 7 | Committed wiper code D (ratio D/128) |
| a_switch_on | output | 1 | 1 = top-terminal switch closed |
| wb_short | output | 1 | 1 = wiper tied to bottom terminal |
| sdo_pull_low | output | 1 | Open-drain enable: 1 pulls the serial output low |

## Verification
The assertions assume that every serial input level is held for several core clock cycles, so that each edge appears in the sampled domain exactly once and a data bit is stable when the serial clock edge that takes it is sampled. The stimulus changes inputs only on the falling edge of the core clock and holds each serial clock phase for four core cycles. It sets up data while the serial clock is low. The one case where two edges meet in the same cycle is driven on purpose: select and the serial clock are changed at the same instant to exercise R10. Two controllers are chained through a pull-up model so that R2 and R10 can be seen from the ports.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int unsigned DPOT_W       = 7;
  localparam int unsigned DPOT_SYNC    = 2;
  localparam int unsigned DPOT_NSIG    = 4;
  localparam int unsigned SIG_SCLK     = 0;
  localparam int unsigned SIG_CSN      = 1;
  localparam int unsigned SIG_SDI      = 2;
  localparam int unsigned SIG_SHDN     = 3;

  typedef logic [DPOT_W-1:0] code_t;

  // centre of the divider: half of 2**W
  function automatic code_t centre_code();
    code_t c;
    c = '0;
    c[DPOT_W-1] = 1'b1;
    return c;
  endfunction

  // next shift-register value: old bits move up, new bit enters at bit 0
  function automatic code_t shift_in(input code_t cur, input logic bit_in);
    return {cur[DPOT_W-2:0], bit_in};
  endfunction
endpackage

// File: rtl/dpot_in_sync.sv
module dpot_in_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dpot_shift_reg.sv
module dpot_shift_reg
  import dpot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_en,
  input  logic  bit_in,
  output code_t sr_o,
  output logic  msb_o
);
  code_t sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= shift_in(sr_q, bit_in);
  end

  assign sr_o  = sr_q;
  assign msb_o = sr_q[DPOT_W-1];

  // R1: one place up, new bit at the bottom
  a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q == {$past(sr_q[DPOT_W-2:0]), $past(bit_in)});

  // R5: no shift request, contents hold
  a_r5_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/dpot_wiper_latch.sv
module dpot_wiper_latch
  import dpot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  code_t d,
  output code_t q
);
  code_t q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= centre_code();
    else if (load) q_r <= d;
  end

  assign q = q_r;

  // R4: a commit takes the shift register value of that cycle
  a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_r == $past(d));

  // R5 / R9: without a commit the code never moves
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q_r));
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rs_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              shdn_n,
  output logic [DPOT_W-1:0] wiper_code,
  output logic              a_switch_on,
  output logic              wb_short,
  output logic              sdo_pull_low
);
  localparam logic [DPOT_NSIG-1:0] SYNC_RST = 4'b1010; // shdn_n=1, sdi=0, cs_n=1, sclk=0

  logic [DPOT_NSIG-1:0] raw_in, lvl, rise, fall;
  code_t sr_val;
  logic  sr_msb;

  // named internal events
  logic shift_evt, commit_evt, shdn_act;

  assign raw_in = {shdn_n, sdi, cs_n, sclk};

  dpot_in_sync #(
    .WIDTH  (DPOT_NSIG),
    .STAGES (DPOT_SYNC),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rs_n),
    .async_i(raw_in),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  // a select edge in the same sampled cycle as a clock edge: select level is
  // already high, so the clock edge does not shift and the commit sees old data
  assign commit_evt = rise[SIG_CSN];
  assign shift_evt  = rise[SIG_SCLK] & ~lvl[SIG_CSN];
  assign shdn_act   = ~lvl[SIG_SHDN];

  dpot_shift_reg u_sr (
    .clk     (clk),
    .rst_n   (rs_n),
    .shift_en(shift_evt),
    .bit_in  (lvl[SIG_SDI]),
    .sr_o    (sr_val),
    .msb_o   (sr_msb)
  );

  dpot_wiper_latch u_latch (
    .clk  (clk),
    .rst_n(rs_n),
    .load (commit_evt),
    .d    (sr_val),
    .q    (wiper_code)
  );

  assign a_switch_on  = ~shdn_act;
  assign wb_short     = shdn_act;
  assign sdo_pull_low = ~shdn_act & ~sr_msb;

  logic unused_fall;
  assign unused_fall = ^fall;

  // R8: in shutdown the output stage is released
  a_r8_release: assert property (@(posedge clk) disable iff (!rs_n)
    wb_short |-> !sdo_pull_low);

  // R10: a commit cycle never shifts
  a_r10_no_shift_on_commit: assert property (@(posedge clk) disable iff (!rs_n)
    commit_evt |-> !shift_evt);
endmodule

// File: tb/dpot_ctrl_tb.sv
module dpot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  // {nbits, data (sent MSB first), expected code}
  localparam logic [27:0] VECS [0:6] = '{
    {5'd7,  16'h007F, 7'h7F},
    {5'd7,  16'h0000, 7'h00},
    {5'd7,  16'h0001, 7'h01},
    {5'd10, 16'h03A5, 7'h25},
    {5'd7,  16'h0040, 7'h40},
    {5'd12, 16'h0ABC, 7'h3C},
    {5'd3,  16'h0005, 7'h65}
  };

  logic clk = 0, rs_n = 0, sclk = 0, cs_n = 1, sdi = 0, shdn_n = 1;
  logic [6:0] wip1, wip2;
  logic a1, wb1, pl1, a2, wb2, pl2;
  logic sdo1_line, sdo2_line;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpot_ctrl dut_i (.clk(clk), .rs_n(rs_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .shdn_n(shdn_n), .wiper_code(wip1), .a_switch_on(a1), .wb_short(wb1),
    .sdo_pull_low(pl1));

  // pull-up resolves the open-drain node
  assign sdo1_line = pl1 ? 1'b0 : 1'b1;
  assign sdo2_line = pl2 ? 1'b0 : 1'b1;

  dpot_ctrl chain_i (.clk(clk), .rs_n(rs_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdo1_line),
    .shdn_n(shdn_n), .wiper_code(wip2), .a_switch_on(a2), .wb_short(wb2),
    .sdo_pull_low(pl2));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input int n, input logic [15:0] data);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = data[i];
      cyc(HALF_BIT);
      sclk = 1;
      cyc(HALF_BIT);
      sclk = 0;
    end
  endtask

  task automatic frame(input int n, input logic [15:0] data);
    cs_n = 0;
    cyc(HALF_BIT);
    send_bits(n, data);
    cyc(HALF_BIT);
    cs_n = 1;
    cyc(6);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(5);
    check("R6 reset code", 16'(wip1), 16'h40);
    check("R6 reset sdo cleared", 16'(sdo1_line), 16'h0);
    check("R8 switch closed after reset", 16'(a1), 16'h1);
    rs_n = 1;
    cyc(4);

    // table walk: R1 R3 R4, R2 via output level (bit 6 of committed code)
    foreach (VECS[k]) begin
      frame(int'(VECS[k][27:23]), VECS[k][22:7]);
      check("R4/R3 committed code", 16'(wip1), 16'(VECS[k][6:0]));
      check("R2 sdo shows bit 6", 16'(sdo1_line), 16'(VECS[k][6]));
    end

    // R2 chain of two: 14 bits, first 7 to the far device
    frame(14, {2'b00, 7'h12, 7'h6B});
    check("R2 chain near", 16'(wip1), 16'h6B);
    check("R2 chain far", 16'(wip2), 16'h12);
    check("R2 far sdo", 16'(sdo2_line), 16'h0);

    // R10: select rises together with a clock rise
    cs_n = 0;
    cyc(HALF_BIT);
    send_bits(7, 16'h002A);
    sdi = 1;
    cyc(HALF_BIT);
    sclk = 1;
    cs_n = 1;
    cyc(HALF_BIT);
    sclk = 0;
    cyc(6);
    check("R10 near commits pre-edge", 16'(wip1), 16'h2A);
    check("R10 far commits pre-edge", 16'(wip2), 16'h6B);

    // R5: clocks with select high change nothing
    send_bits(7, 16'h0011);
    cyc(6);
    check("R5 latch unchanged", 16'(wip1), 16'h2A);
    frame(0, 16'h0);
    check("R5 shift register unchanged", 16'(wip1), 16'h2A);

    // R8 / R9 shutdown
    shdn_n = 0;
    cyc(6);
    check("R8 a switch open", 16'(a1), 16'h0);
    check("R8 w tied to b", 16'(wb1), 16'h1);
    check("R8 sdo released", 16'(sdo1_line), 16'h1);
    check("R9 code kept in shutdown", 16'(wip1), 16'h2A);
    shdn_n = 1;
    cyc(6);
    check("R9 switch restored", 16'(a1), 16'h1);
    check("R9 sdo restored", 16'(sdo1_line), 16'h0);

    // R6 / R7 reset with select low and clocks running
    frame(7, 16'h0055);
    check("R4 pre-reset code", 16'(wip1), 16'h55);
    cs_n = 0;
    cyc(2);
    rs_n = 0;
    cyc(3);
    send_bits(3, 16'h0007);
    check("R6 reset overrides", 16'(wip1), 16'h40);
    check("R6 sdo cleared", 16'(sdo1_line), 16'h0);
    cs_n = 1;
    cyc(6);
    rs_n = 1;
    cyc(6);
    send_bits(4, 16'h000F);
    cyc(6);
    check("R7 code stays centre", 16'(wip1), 16'h40);
    frame(0, 16'h0);
    check("R6 shift register cleared", 16'(wip1), 16'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule